// File: doc/BRIEF.md
# Angle Converter Freeze-and-Read Interface

This block sits between a host bus and a pair of continuously tracking angle converters, one coarse and one fine. Each converter produces a 14-bit binary angle over a full turn. The angle keeps changing while the converter tracks, so the host must stop updates before it reads. A single hold register, written by software, drives both active-low inhibit lines. While the hold is set, the block waits a fixed number of settle cycles and then takes one snapshot of both angles. The host reads each snapshot as one 16-bit word at a single address. Writing the release value, or letting a hold timeout expire, lets tracking resume.

A typical host sequence has four steps. First write 0 to the control address. Then poll status until the settled bit is set. Next read the coarse word and the fine word. Finally write 1 to the control address. A word read made while the converters are tracking still returns the last snapshot, but it marks the data as not fresh and sets a sticky error flag. Merging the coarse and fine words into one angle, and correcting gross errors between them, belong to the host.

Top module: `angle_freeze_if`

## Requirements
- R1: After reset both inhibit lines are high, `rd_ack`, `rd_fresh` and `read_err` are 0, and a status read returns 0.
- R2: A write to address 0 with `host_wbit` = 0, made while the hold is clear, drives both inhibit lines low from the next cycle on. A write to address 0 with `host_wbit` = 1 drives both lines high from the next cycle on. A write of 0 while the hold is already set has no effect.
- R3: The hold counts as settled once SETTLE clock edges have passed since it was set. Settled clears on release.
- R4: At the edge that makes the hold settled, both converter angles are captured. The snapshot then stays constant until the next capture, whatever the converter inputs do.
- R5: Address 1 returns the coarse snapshot and address 2 returns the fine snapshot, each zero-extended to 16 bits with bits 15:14 reading 0.
- R6: A read of address 1 or 2 while the hold is clear returns the last snapshot, with `rd_fresh` = 0. It also sets `read_err`, which stays at 1 until reset.
- R7: A hold releases by itself after TIMEOUT cycles (default 1024), so the inhibit lines are low for exactly TIMEOUT cycles when nothing else releases them.
- R8: A read strobe gives `rd_ack` = 1 with its data on the following cycle. `rd_fresh` is 1 only for a word read made while the hold was set and settled. Reads use the state from before the edge at which they are made.
- R9: Address 3 reads as 0. Writes to addresses 1, 2 and 3 change nothing.
- R10: Address 0 reads status: bit 0 is hold set, bit 1 is settled, bit 2 is the sticky error, and the other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_addr | input | 2 | 0 control/status, 1 coarse, 2 fine, 3 spare |
| host_wbit | input | 1 | Write data: 0 sets the hold, 1 releases it |
| coarse_angle | input | 14 | Coarse converter angle |
| fine_angle | input | 14 | Fine converter angle |
| coarse_inhibit_n | output | 1 | Active-low inhibit to the coarse converter |
| fine_inhibit_n | output | 1 | Active-low inhibit to the fine converter |
| rd_ack | output | 1 | Read data is present this cycle |
| rd_data | output | 16 | Read data |
| rd_fresh | output | 1 | Word came from a settled hold |
| read_err | output | 1 | Sticky flag for a word read made while tracking |

## Verification
The hardest case to reach is the boundary where the hold ends by timeout. It takes more than a thousand cycles of holding with no host release, and the bench must confirm that the inhibit lines stay low for exactly TIMEOUT cycles. The stimulus sets the hold, then leaves the bus idle while it counts low cycles on the inhibit line. The free-running converter inputs keep changing during this time, which also shows that the snapshot does not move. A read and a release in the same cycle, and a word read made while tracking after a capture, are aimed at the order in which the old state is used.

// File: rtl/afi_pkg.sv
`timescale 1ns/1ps
package afi_pkg;
  localparam int ANGLE_W = 14;
  localparam int WORD_W  = 16;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_COARSE = 2'd1,
    SEL_FINE   = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  function automatic logic [WORD_W-1:0] widen_angle(input logic [ANGLE_W-1:0] a);
    return {{(WORD_W-ANGLE_W){1'b0}}, a};
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic hold, input logic settled,
                                                    input logic err);
    return {{(WORD_W-3){1'b0}}, err, settled, hold};
  endfunction

  function automatic logic is_word_sel(input logic [1:0] sel);
    return (sel == SEL_COARSE) || (sel == SEL_FINE);
  endfunction
endpackage

// File: rtl/afi_hold_ctrl.sv
`timescale 1ns/1ps
module afi_hold_ctrl #(
  parameter int SETTLE  = 4,
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_hold,
  input  logic req_release,
  output logic hold,
  output logic settled,
  output logic capture,
  output logic timeout_hit
);
  localparam int AGE_W = $clog2(TIMEOUT + 1);

  logic [AGE_W-1:0] age;

  assign capture     = hold && (age == AGE_W'(SETTLE - 1));
  assign timeout_hit = hold && (age == AGE_W'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold    <= 1'b0;
      settled <= 1'b0;
      age     <= '0;
    end else if (req_release || timeout_hit) begin
      hold    <= 1'b0;
      settled <= 1'b0;
      age     <= '0;
    end else if (req_hold && !hold) begin
      hold    <= 1'b1;
      settled <= 1'b0;
      age     <= '0;
    end else if (hold) begin
      age <= age + 1'b1;
      if (capture) settled <= 1'b1;
    end
  end

  p_hold_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hold && !req_release && !hold) |=> hold);
  p_release_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_release |=> !hold);
  p_settled_needs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> hold);
  p_timeout_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> (!hold && !settled));
endmodule

// File: rtl/afi_snapshot.sv
`timescale 1ns/1ps
module afi_snapshot #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] din,
  output logic [W-1:0] snap
);
  always_ff @(posedge clk) begin
    if (!rst_n)       snap <= '0;
    else if (capture) snap <= din;
  end

  p_snap_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(snap));
endmodule

// File: rtl/afi_read_port.sv
`timescale 1ns/1ps
module afi_read_port
  import afi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  logic [1:0]         rd_sel,
  input  logic               hold,
  input  logic               settled,
  input  logic [ANGLE_W-1:0] snap_coarse,
  input  logic [ANGLE_W-1:0] snap_fine,
  output logic               rd_ack,
  output logic [WORD_W-1:0]  rd_data,
  output logic               rd_fresh,
  output logic               read_err
);
  logic              word_rd;
  logic              bad_rd;
  logic [WORD_W-1:0] mux_word;

  assign word_rd = rd_stb && is_word_sel(rd_sel);
  assign bad_rd  = word_rd && !hold;

  always_comb begin
    unique case (rd_sel)
      SEL_CTRL:   mux_word = pack_status(hold, settled, read_err);
      SEL_COARSE: mux_word = widen_angle(snap_coarse);
      SEL_FINE:   mux_word = widen_angle(snap_fine);
      default:    mux_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ack   <= 1'b0;
      rd_data  <= '0;
      rd_fresh <= 1'b0;
      read_err <= 1'b0;
    end else begin
      rd_ack   <= rd_stb;
      rd_fresh <= word_rd && hold && settled;
      if (rd_stb) rd_data <= mux_word;
      if (bad_rd) read_err <= 1'b1;
    end
  end

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    read_err |=> read_err);
  p_ack_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_ack);
  p_fresh_needs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fresh |-> ($past(hold) && $past(settled)));
endmodule

// File: rtl/angle_freeze_if.sv
`timescale 1ns/1ps
module angle_freeze_if
  import afi_pkg::*;
#(
  parameter int SETTLE  = 4,
  parameter int TIMEOUT = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [1:0]         host_addr,
  input  logic               host_wbit,
  input  logic [ANGLE_W-1:0] coarse_angle,
  input  logic [ANGLE_W-1:0] fine_angle,
  output logic               coarse_inhibit_n,
  output logic               fine_inhibit_n,
  output logic               rd_ack,
  output logic [WORD_W-1:0]  rd_data,
  output logic               rd_fresh,
  output logic               read_err
);
  localparam int NCH = 2;

  logic ctrl_wr, req_hold, req_release;
  logic hold, settled, capture, timeout_hit;
  logic [NCH-1:0][ANGLE_W-1:0] conv_in;
  logic [NCH-1:0][ANGLE_W-1:0] snap_q;

  assign ctrl_wr     = host_wr && (host_addr == SEL_CTRL);
  assign req_hold    = ctrl_wr && !host_wbit;
  assign req_release = ctrl_wr && host_wbit;

  afi_hold_ctrl #(.SETTLE(SETTLE), .TIMEOUT(TIMEOUT)) u_hold (
    .clk(clk), .rst_n(rst_n), .req_hold(req_hold), .req_release(req_release),
    .hold(hold), .settled(settled), .capture(capture), .timeout_hit(timeout_hit)
  );

  assign conv_in[0] = coarse_angle;
  assign conv_in[1] = fine_angle;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    afi_snapshot #(.W(ANGLE_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .capture(capture),
      .din(conv_in[ch]), .snap(snap_q[ch])
    );
  end

  assign coarse_inhibit_n = !hold;
  assign fine_inhibit_n   = !hold;

  afi_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(host_rd), .rd_sel(host_addr),
    .hold(hold), .settled(settled), .snap_coarse(snap_q[0]), .snap_fine(snap_q[1]),
    .rd_ack(rd_ack), .rd_data(rd_data), .rd_fresh(rd_fresh), .read_err(read_err)
  );

  p_lines_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_inhibit_n == fine_inhibit_n);
  p_release_after_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> coarse_inhibit_n);
endmodule

// File: tb/angle_freeze_if_tb.sv
`timescale 1ns/1ps
module angle_freeze_if_tb;
  localparam int SETTLE  = 4;
  localparam int TIMEOUT = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, host_wbit = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [13:0] coarse_angle = '0, fine_angle = '0;
  logic coarse_inhibit_n, fine_inhibit_n, rd_ack, rd_fresh, read_err;
  logic [15:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  bit pin_inputs = 1'b0;
  logic [13:0] pin_c = '0, pin_f = '0;
  int tick = 0;

  always #2 clk = ~clk;

  angle_freeze_if #(.SETTLE(SETTLE), .TIMEOUT(TIMEOUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wbit(host_wbit),
    .coarse_angle(coarse_angle), .fine_angle(fine_angle),
    .coarse_inhibit_n(coarse_inhibit_n), .fine_inhibit_n(fine_inhibit_n),
    .rd_ack(rd_ack), .rd_data(rd_data), .rd_fresh(rd_fresh), .read_err(read_err)
  );

  // free-running converter stimulus
  always @(negedge clk) begin
    tick = tick + 1;
    if (pin_inputs) begin
      coarse_angle = pin_c;
      fine_angle   = pin_f;
    end else begin
      coarse_angle = 14'((tick * 613 + 5) & 16'h3FFF);
      fine_angle   = 14'(((tick * 2731) ^ (tick << 3)) & 16'h3FFF);
    end
  end

  // behavioural reference model
  bit m_hold, m_settled, m_err, m_ack, m_fresh;
  int m_age;
  logic [13:0] m_sc, m_sf;
  logic [15:0] m_data;

  always @(posedge clk) begin
    bit grab, wordr, relz;
    if (!rst_n) begin
      m_hold = 0; m_settled = 0; m_err = 0; m_ack = 0; m_fresh = 0;
      m_age = 0; m_sc = '0; m_sf = '0; m_data = '0;
    end else begin
      grab  = m_hold && (m_age == SETTLE - 1);
      wordr = (host_addr == 2'd1) || (host_addr == 2'd2);
      m_ack   = host_rd;
      m_fresh = host_rd && wordr && m_hold && m_settled;
      if (host_rd) begin
        case (host_addr)
          2'd0: m_data = 16'(m_err) * 4 + 16'(m_settled) * 2 + 16'(m_hold);
          2'd1: m_data = 16'(m_sc);
          2'd2: m_data = 16'(m_sf);
          default: m_data = 16'd0;
        endcase
      end
      if (host_rd && wordr && !m_hold) m_err = 1;
      if (grab) begin m_sc = coarse_angle; m_sf = fine_angle; end
      relz = (host_wr && host_addr == 2'd0 && host_wbit) ||
             (m_hold && m_age == TIMEOUT - 1);
      if (relz) begin
        m_hold = 0; m_settled = 0; m_age = 0;
      end else if (host_wr && host_addr == 2'd0 && !host_wbit && !m_hold) begin
        m_hold = 1; m_settled = 0; m_age = 0;
      end else if (m_hold) begin
        if (m_age == SETTLE - 1) m_settled = 1;
        m_age = m_age + 1;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    bit bad;
    if (rst_n) begin
      bad = 0;
      n_cmp = n_cmp + 1;
      if (coarse_inhibit_n !== !m_hold || fine_inhibit_n !== !m_hold) begin
        bad = 1;
        $display("FAIL R2 inhibit c=%b f=%b expected %b", coarse_inhibit_n, fine_inhibit_n, !m_hold);
      end
      if (rd_ack !== m_ack) begin
        bad = 1; $display("FAIL R8 rd_ack=%b expected %b", rd_ack, m_ack);
      end
      if (rd_data !== m_data) begin
        bad = 1; $display("FAIL R4 rd_data=%h expected %h", rd_data, m_data);
      end
      if (rd_fresh !== m_fresh) begin
        bad = 1; $display("FAIL R3 rd_fresh=%b expected %b", rd_fresh, m_fresh);
      end
      if (read_err !== m_err) begin
        bad = 1; $display("FAIL R6 read_err=%b expected %b", read_err, m_err);
      end
      if (bad) n_bad = n_bad + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); host_wr = 0; host_rd = 0;
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic b);
    @(negedge clk); host_wr = 1; host_rd = 0; host_addr = a; host_wbit = b;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic do_read(input logic [1:0] a);
    @(negedge clk); host_rd = 1; host_wr = 0; host_addr = a;
    @(negedge clk); host_rd = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad = n_bad + 1;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lowcnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 inhibit", {coarse_inhibit_n, fine_inhibit_n}, 2'b11);
    chk("R1 ack/err", {rd_ack, rd_fresh, read_err}, 3'b000);
    do_read(2'd0);
    chk("R1 status", rd_data, 16'h0000);

    // R2 set hold with pinned inputs
    pin_c = 14'h2ABC; pin_f = 14'h3FFF; pin_inputs = 1;
    idle(1);
    do_write(2'd0, 1'b0);
    chk("R2 hold low", {coarse_inhibit_n, fine_inhibit_n}, 2'b00);
    do_read(2'd1);
    chk("R3 not yet settled", rd_fresh, 1'b0);
    idle(6);
    pin_inputs = 0;
    do_read(2'd1);
    chk("R3 fresh after settle", rd_fresh, 1'b1);
    chk("R4 coarse snapshot", rd_data, 16'h2ABC);
    do_read(2'd2);
    chk("R5 fine zero-extended", rd_data, 16'h3FFF);
    chk("R5 top bits", rd_data[15:14], 2'b00);
    do_read(2'd0);
    chk("R10 status held+settled", rd_data, 16'h0003);
    do_read(2'd3);
    chk("R9 spare reads zero", rd_data, 16'h0000);
    do_write(2'd1, 1'b1);
    do_write(2'd3, 1'b1);
    chk("R9 write elsewhere ignored", coarse_inhibit_n, 1'b0);
    idle(5);
    do_read(2'd1);
    chk("R4 snapshot stable", rd_data, 16'h2ABC);

    // R8 read and release in the same cycle
    @(negedge clk); host_rd = 1; host_wr = 1; host_addr = 2'd0; host_wbit = 1;
    @(negedge clk); host_rd = 0; host_wr = 0;
    chk("R8 status from old state", rd_data, 16'h0003);
    chk("R2 release", {coarse_inhibit_n, fine_inhibit_n}, 2'b11);

    // R6 read while tracking
    do_read(2'd1);
    chk("R6 last snapshot", rd_data, 16'h2ABC);
    chk("R6 flags", {rd_fresh, read_err}, 2'b01);
    do_read(2'd0);
    chk("R10 status err", rd_data, 16'h0004);

    // R7 timeout
    do_write(2'd0, 1'b0);
    lowcnt = 0;
    for (int i = 0; i < TIMEOUT + 20; i++) begin
      if (!coarse_inhibit_n) lowcnt = lowcnt + 1;
      @(negedge clk);
    end
    chk("R7 hold length", lowcnt, TIMEOUT);
    chk("R7 released", coarse_inhibit_n, 1'b1);

    // varying inputs, second capture, write of 0 while held ignored
    do_write(2'd0, 1'b0);
    idle(2);
    do_write(2'd0, 1'b0);
    idle(4);
    do_read(2'd2);
    chk("R2 rewrite keeps settle", rd_fresh, 1'b1);
    do_write(2'd0, 1'b1);
    do_read(2'd0);
    chk("R6 err sticky", rd_data, 16'h0004);
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule